// File: doc/BRIEF.md
# Two-Wire Serial Packet Receiver with Turnaround Timer

This block takes a two-wire differential line that has already been sampled once per bit time and turns it back into a short fixed-format packet. It decodes the transition-based line coding and waits for a start pattern after an idle line. It then strips the zero bits the transmitter inserted to keep transitions on the line, and collects 28 payload bits. Those bits hold a 3-bit packet number, a 4-bit address, a 16-bit data word and a 5-bit check code. The packet closes when both wires go low. Only a packet with the right length and a correct check code is presented with a valid strobe. Each kind of failure gets its own one-cycle flag instead.

The block also watches the line after the host's own transmitter finishes. If the line stays idle for the whole response window, it reports a turnaround timeout. A very long stretch with both wires low is reported as a bus reset, which is kept separate from a normal end of packet.

Top module: `pkt_line_rx`

## Requirements
- R1: Each sample that is not SE0 decodes to 1 when `line_p` equals its value at the previous sample and to 0 when it differs. After an SE0 sample the previous level counts as J (`line_p`=1, `line_n`=0).
- R2: The receiver arms only when the last five decoded bits, oldest first, are 1,0,0,0,1. From idle J this is the line sequence K, J, K, K. No flag or strobe can fire before that.
- R3: After the start pattern the payload bits arrive LSb first: packet number (3 bits), then address (4 bits), then data (16 bits), then the 5 check bits. On a good packet `pkt_valid` is high for one cycle after the edge that samples the second SE0. The fields update at that same edge and otherwise hold their value.
- R4: A run counter starts at zero on the first bit after the start pattern. When six consecutive decoded 1s have been accepted, the next bit is a 0 that is dropped. It does not count toward the 28 payload bits.
- R5: If a seventh consecutive 1 arrives instead, `stuff_err` pulses for one cycle after that sample. The packet is abandoned and the fields keep their value.
- R6: The check code uses x^5+x^2+1 with the register preset to all ones. Sending is the complement of the register, highest bit first. The receiver runs all 28 bits through the generator and expects the residue 5'b01100. On a mismatch `crc_err` pulses in place of `pkt_valid` and the fields hold.
- R7: If the count of kept bits is not 28 when the end of packet arrives, `frame_err` pulses and nothing else is reported.
- R8: An end of packet is two consecutive SE0 samples inside a packet. A single SE0 followed by a non-SE0 sample raises `frame_err` one cycle after that sample.
- R9: After the edge that samples `tx_done`, `turn_timeout` pulses for one cycle after edge number TURN_TO (16 to 18) if every sample from the next edge through that one was J. Any non-J sample in that span cancels it.
- R10: `bus_reset` goes high after RESET_CYC consecutive SE0 samples and falls after the first non-SE0 sample. A two-sample SE0 while idle raises neither it nor any packet flag.
- R11: While reset is held low and just after it is released, all outputs are zero.
- R12: `pkt_valid`, `crc_err`, `stuff_err` and `frame_err` are single-cycle pulses and never more than one at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | One rising edge per bit time |
| rst_n | input | 1 | Active-low synchronous reset |
| line_p | input | 1 | Positive wire sample |
| line_n | input | 1 | Negative wire sample |
| tx_done | input | 1 | Pulse: own transmission has just ended |
| pkt_valid | output | 1 | Good packet strobe |
| pkt_num | output | PNUM_W | Received packet number |
| pkt_addr | output | ADDR_W | Received address |
| pkt_data | output | DATA_W | Received data word |
| crc_err | output | 1 | Check code mismatch pulse |
| stuff_err | output | 1 | Seven-ones violation pulse |
| frame_err | output | 1 | Wrong length or broken end-of-packet pulse |
| turn_timeout | output | 1 | No response within the window |
| bus_reset | output | 1 | Long SE0 detected |

## Verification
The bench sends 131 packets across every packet-number and address pair, including all-ones data that forces several dropped zeros. A receiver that miscounts the run or keeps the stuffed zero would put the fields one bit off or raise a false check-code error. Packets that are one bit short or long, packets with a flipped check bit, and a seven-ones run each probe a single flag. The timeout is swept with the response arriving on exactly the last allowed sample and on the one after it, which catches an off-by-one window. An SE0 run one sample shorter than the reset threshold, and a two-sample SE0 while idle, check that end of packet and bus reset are not confused.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  localparam int CRC5_W = 5;
  localparam logic [CRC5_W-1:0] CRC5_POLY  = 5'b00101;
  localparam logic [CRC5_W-1:0] CRC5_RESID = 5'b01100;
  localparam logic [4:0] SYNC_PAT = 5'b10001;
  localparam int STUFF_RUN = 6;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_DATA = 2'd1,
    RX_EOP1 = 2'd2
  } rx_state_e;

  // transition coding: same level -> 1, change -> 0
  function automatic logic nrzi_bit(input logic prev_lvl, input logic cur_lvl);
    return ~(prev_lvl ^ cur_lvl);
  endfunction

  // one serial step of the x^5+x^2+1 generator, top bit first out
  function automatic logic [CRC5_W-1:0] crc5_next(input logic [CRC5_W-1:0] c,
                                                  input logic b);
    logic fb;
    fb = b ^ c[CRC5_W-1];
    return {c[CRC5_W-2:0], 1'b0} ^ (fb ? CRC5_POLY : '0);
  endfunction

endpackage

// File: rtl/pkt_rx_line_front.sv
module pkt_rx_line_front
  import pkt_rx_pkg::*;
#(
  parameter int RESET_CYC = 120000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_p,
  input  logic line_n,
  output logic se0,
  output logic line_j,
  output logic dec_bit,
  output logic bus_reset
);

  localparam int RC_W = $clog2(RESET_CYC + 1);
  localparam logic [RC_W-1:0] RC_MAX = RC_W'(RESET_CYC);

  logic            prev_lvl;
  logic [RC_W-1:0] se0_cnt;

  assign se0     = !line_p && !line_n;
  assign line_j  = line_p && !line_n;
  assign dec_bit = nrzi_bit(prev_lvl, line_p);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_lvl <= 1'b1;
      se0_cnt  <= '0;
    end else begin
      prev_lvl <= se0 ? 1'b1 : line_p;
      if (!se0)
        se0_cnt <= '0;
      else if (se0_cnt != RC_MAX)
        se0_cnt <= se0_cnt + 1'b1;
    end
  end

  assign bus_reset = (se0_cnt == RC_MAX);

endmodule

// File: rtl/pkt_rx_deframer.sv
module pkt_rx_deframer
  import pkt_rx_pkg::*;
#(
  parameter int PNUM_W = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              se0,
  input  logic              dec_bit,
  output logic              pkt_valid,
  output logic              crc_err,
  output logic              stuff_err,
  output logic              frame_err,
  output logic [PNUM_W-1:0] pkt_num,
  output logic [ADDR_W-1:0] pkt_addr,
  output logic [DATA_W-1:0] pkt_data,
  output logic              sync_hit,
  output logic              bit_take,
  output logic              bit_drop,
  output logic              eop_hit
);

  localparam int PAY_W   = PNUM_W + ADDR_W + DATA_W;
  localparam int FRAME_W = PAY_W + CRC5_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);
  localparam logic [2:0] RUN_LIM = 3'(STUFF_RUN);

  rx_state_e           state;
  logic [4:0]          hist;
  logic [4:0]          hist_nx;
  logic [2:0]          ones;
  logic [CNT_W-1:0]    cnt;
  logic [CRC5_W-1:0]   crc;
  logic [FRAME_W-1:0]  frame;
  logic                in_data;
  logic                stuff_viol;
  logic                crc_good;

  assign hist_nx    = {hist[3:0], dec_bit};
  assign sync_hit   = (state == RX_IDLE) && !se0 && (hist_nx == SYNC_PAT);
  assign in_data    = (state == RX_DATA) && !se0;
  assign bit_drop   = in_data && (ones == RUN_LIM) && !dec_bit;
  assign stuff_viol = in_data && (ones == RUN_LIM) && dec_bit;
  assign bit_take   = in_data && (ones != RUN_LIM);
  assign eop_hit    = (state == RX_EOP1) && se0;
  assign crc_good   = (crc == CRC5_RESID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      hist      <= '1;
      ones      <= '0;
      cnt       <= '0;
      crc       <= '1;
      frame     <= '0;
      pkt_valid <= 1'b0;
      crc_err   <= 1'b0;
      stuff_err <= 1'b0;
      frame_err <= 1'b0;
      pkt_num   <= '0;
      pkt_addr  <= '0;
      pkt_data  <= '0;
    end else begin
      pkt_valid <= 1'b0;
      crc_err   <= 1'b0;
      stuff_err <= 1'b0;
      frame_err <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          hist <= se0 ? '1 : hist_nx;
          if (sync_hit) begin
            state <= RX_DATA;
            ones  <= '0;
            cnt   <= '0;
            crc   <= '1;
          end
        end
        RX_DATA: begin
          if (se0) begin
            state <= RX_EOP1;
          end else if (stuff_viol) begin
            stuff_err <= 1'b1;
            state     <= RX_IDLE;
            hist      <= '1;
          end else if (bit_drop) begin
            ones <= '0;
          end else begin
            ones  <= dec_bit ? ones + 1'b1 : '0;
            frame <= {dec_bit, frame[FRAME_W-1:1]};
            crc   <= crc5_next(crc, dec_bit);
            if (cnt != CNT_OVER)
              cnt <= cnt + 1'b1;
          end
        end
        RX_EOP1: begin
          state <= RX_IDLE;
          hist  <= '1;
          if (!se0 || cnt != CNT_FULL) begin
            frame_err <= 1'b1;
          end else if (!crc_good) begin
            crc_err <= 1'b1;
          end else begin
            pkt_valid <= 1'b1;
            pkt_num   <= frame[PNUM_W-1:0];
            pkt_addr  <= frame[PNUM_W +: ADDR_W];
            pkt_data  <= frame[PNUM_W+ADDR_W +: DATA_W];
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pkt_rx_turn_timer.sv
module pkt_rx_turn_timer #(
  parameter int TURN_TO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_done,
  input  logic line_j,
  output logic timeout,
  output logic waiting
);

  localparam int TW = $clog2(TURN_TO + 1);
  localparam logic [TW-1:0] TLIM = TW'(TURN_TO);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (tx_done) begin
        waiting <= 1'b1;
        cnt     <= TW'(1);
      end else if (waiting) begin
        if (!line_j) begin
          waiting <= 1'b0;
        end else if (cnt == TLIM) begin
          timeout <= 1'b1;
          waiting <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pkt_line_rx.sv
module pkt_line_rx #(
  parameter int PNUM_W    = 3,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int TURN_TO   = 16,
  parameter int RESET_CYC = 120000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_p,
  input  logic              line_n,
  input  logic              tx_done,
  output logic              pkt_valid,
  output logic [PNUM_W-1:0] pkt_num,
  output logic [ADDR_W-1:0] pkt_addr,
  output logic [DATA_W-1:0] pkt_data,
  output logic              crc_err,
  output logic              stuff_err,
  output logic              frame_err,
  output logic              turn_timeout,
  output logic              bus_reset
);

  if (TURN_TO < 16 || TURN_TO > 18) begin : g_bad_window
    $error("TURN_TO must lie in 16..18");
  end

  logic se0;
  logic line_j;
  logic dec_bit;
  logic sync_hit;
  logic bit_take;
  logic bit_drop;
  logic eop_hit;
  logic turn_wait;

  pkt_rx_line_front #(.RESET_CYC(RESET_CYC)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_p    (line_p),
    .line_n    (line_n),
    .se0       (se0),
    .line_j    (line_j),
    .dec_bit   (dec_bit),
    .bus_reset (bus_reset)
  );

  pkt_rx_deframer #(
    .PNUM_W (PNUM_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_deframe (
    .clk       (clk),
    .rst_n     (rst_n),
    .se0       (se0),
    .dec_bit   (dec_bit),
    .pkt_valid (pkt_valid),
    .crc_err   (crc_err),
    .stuff_err (stuff_err),
    .frame_err (frame_err),
    .pkt_num   (pkt_num),
    .pkt_addr  (pkt_addr),
    .pkt_data  (pkt_data),
    .sync_hit  (sync_hit),
    .bit_take  (bit_take),
    .bit_drop  (bit_drop),
    .eop_hit   (eop_hit)
  );

  pkt_rx_turn_timer #(.TURN_TO(TURN_TO)) u_turn (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_done (tx_done),
    .line_j  (line_j),
    .timeout (turn_timeout),
    .waiting (turn_wait)
  );

endmodule

// File: rtl/pkt_line_rx_chk.sv
module pkt_line_rx_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              se0,
  input logic              line_j,
  input logic              dec_bit,
  input logic              pkt_valid,
  input logic              crc_err,
  input logic              stuff_err,
  input logic              frame_err,
  input logic              turn_timeout,
  input logic              turn_wait,
  input logic              bus_reset,
  input logic [DATA_W-1:0] pkt_data
);

  // R12
  exclusive_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_valid, crc_err, stuff_err, frame_err}));

  // R9
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    turn_timeout |-> $past(line_j));

  // R9
  timeout_ends_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    turn_timeout |-> !turn_wait);

  // R10
  reset_se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |-> $past(se0));

  // R8
  eop_two_se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> ($past(se0) && $past(se0, 2)));

  // R3
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_data != $past(pkt_data)) |-> pkt_valid);

  // R5
  stuff_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> ($past(dec_bit) && !$past(se0)));

endmodule

bind pkt_line_rx pkt_line_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .se0          (se0),
  .line_j       (line_j),
  .dec_bit      (dec_bit),
  .pkt_valid    (pkt_valid),
  .crc_err      (crc_err),
  .stuff_err    (stuff_err),
  .frame_err    (frame_err),
  .turn_timeout (turn_timeout),
  .turn_wait    (turn_wait),
  .bus_reset    (bus_reset),
  .pkt_data     (pkt_data)
);

// File: tb/pkt_line_rx_bench.sv
module pkt_line_rx_bench;

  localparam int CLK_NS = 10;
  localparam int TO     = 16;
  localparam int RC     = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_p = 1'b1;
  logic line_n = 1'b0;
  logic tx_done = 1'b0;
  logic        pkt_valid, crc_err, stuff_err, frame_err, turn_timeout, bus_reset;
  logic [2:0]  pkt_num;
  logic [3:0]  pkt_addr;
  logic [15:0] pkt_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic lvl = 1'b1;
  int ones = 0;
  logic [2:0]  last_pn = '0;
  logic [3:0]  last_ad = '0;
  logic [15:0] last_dt = '0;

  always #(CLK_NS/2) clk = ~clk;

  pkt_line_rx #(.TURN_TO(TO), .RESET_CYC(RC)) u_pkt_line_rx (
    .clk(clk), .rst_n(rst_n), .line_p(line_p), .line_n(line_n), .tx_done(tx_done),
    .pkt_valid(pkt_valid), .pkt_num(pkt_num), .pkt_addr(pkt_addr), .pkt_data(pkt_data),
    .crc_err(crc_err), .stuff_err(stuff_err), .frame_err(frame_err),
    .turn_timeout(turn_timeout), .bus_reset(bus_reset)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] flags();
    return {pkt_valid, crc_err, stuff_err, frame_err, turn_timeout, bus_reset, 1'b0};
  endfunction

  // called at a falling edge, returns at the next falling edge
  task automatic put(input logic p, input logic n);
    line_p = p;
    line_n = n;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nrzi(input logic b);
    if (!b) lvl = ~lvl;
    put(lvl, ~lvl);
  endtask

  task automatic sbit(input logic b);
    nrzi(b);
    if (b) ones++; else ones = 0;
    if (ones == 6) begin
      nrzi(1'b0);
      ones = 0;
    end
  endtask

  task automatic idle(input int n);
    lvl = 1'b1;
    for (int i = 0; i < n; i++) put(1'b1, 1'b0);
  endtask

  task automatic sync();
    nrzi(1'b0); nrzi(1'b0); nrzi(1'b0); nrzi(1'b1);
    ones = 0;
  endtask

  // explicit bit equations of x^5+x^2+1, preset ones, LSb-first payload
  function automatic logic [4:0] ref_crc(input logic [22:0] pay);
    logic [4:0] r;
    logic fb;
    r = 5'b11111;
    for (int i = 0; i < 23; i++) begin
      fb = pay[i] ^ r[4];
      r = {r[3], r[2], r[1] ^ fb, r[0], fb};
    end
    return r;
  endfunction

  // mode 0 normal, 1 flip a check bit, 2 one bit short, 3 one bit long
  task automatic send_frame(input logic [2:0] pn, input logic [3:0] ad,
                            input logic [15:0] dt, input int mode);
    logic [22:0] pay;
    logic [4:0]  cr;
    pay = {dt, ad, pn};
    cr  = ~ref_crc(pay);
    if (mode == 1) cr[0] = ~cr[0];
    idle(2);
    sync();
    for (int i = 0; i < 23; i++) sbit(pay[i]);
    for (int i = 4; i >= 0; i--) begin
      if (!(mode == 2 && i == 0)) sbit(cr[i]);
    end
    if (mode == 3) sbit(1'b0);
    put(1'b0, 1'b0);
    chk(flags() == 7'b0, "R8", "flags after first SE0", 32'(flags()), 32'h0);
    put(1'b0, 1'b0);
  endtask

  task automatic good_pkt(input logic [2:0] pn, input logic [3:0] ad, input logic [15:0] dt);
    send_frame(pn, ad, dt, 0);
    chk(pkt_valid && !crc_err && !frame_err && !stuff_err, "R3", "valid strobe",
        32'({pkt_valid, crc_err, frame_err, stuff_err}), 32'h8);
    chk({pkt_num, pkt_addr, pkt_data} == {pn, ad, dt}, "R4", "fields R1 R3",
        32'({pkt_num, pkt_addr, pkt_data}), 32'({pn, ad, dt}));
    last_pn = pn; last_ad = ad; last_dt = dt;
    idle(1);
    chk(flags() == 7'b0, "R12", "strobe one cycle", 32'(flags()), 32'h0);
  endtask

  task automatic held(input string req);
    chk({pkt_num, pkt_addr, pkt_data} == {last_pn, last_ad, last_dt}, req, "fields held",
        32'({pkt_num, pkt_addr, pkt_data}), 32'({last_pn, last_ad, last_dt}));
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk(flags() == 7'b0 && pkt_data == '0, "R11", "outputs in reset",
          32'({flags(), pkt_data}), 32'h0);
      @(negedge clk);
    end
    rst_n = 1'b1;
    idle(3);
    chk(flags() == 7'b0 && {pkt_num, pkt_addr, pkt_data} == '0, "R11", "outputs after reset",
        32'({pkt_num, pkt_addr, pkt_data}), 32'h0);

    // R2: a lone K and stray toggles do not arm
    put(1'b0, 1'b1); put(1'b1, 1'b0); put(1'b1, 1'b0);
    put(1'b0, 1'b0); put(1'b0, 1'b0);
    chk(flags() == 7'b0, "R2", "no arm without start pattern", 32'(flags()), 32'h0);
    idle(2);

    // R1 R3 R4 sweep of every number/address pair
    for (int i = 0; i < 128; i++) begin
      logic [15:0] dt;
      dt = 16'(i * 16'hA5C3) ^ 16'(i << 9);
      good_pkt(3'(i), 4'(i >> 3), dt);
    end
    good_pkt(3'd0, 4'd0, 16'h0000);
    good_pkt(3'd7, 4'd15, 16'hFFFF);
    good_pkt(3'd5, 4'd10, 16'h7E7E);

    // R6 check-code mismatch
    send_frame(3'd2, 4'd9, 16'h1234, 1);
    chk(crc_err && !pkt_valid, "R6", "crc_err on flipped bit",
        32'({crc_err, pkt_valid}), 32'h2);
    held("R6");
    idle(1);

    // R7 length errors
    send_frame(3'd3, 4'd3, 16'h5555, 2);
    chk(frame_err && !pkt_valid && !crc_err, "R7", "short frame",
        32'({frame_err, pkt_valid, crc_err}), 32'h4);
    held("R7");
    send_frame(3'd3, 4'd3, 16'h5555, 3);
    chk(frame_err && !pkt_valid && !crc_err, "R7", "long frame",
        32'({frame_err, pkt_valid, crc_err}), 32'h4);
    held("R7");
    idle(1);

    // R8 single SE0 inside a packet
    idle(2);
    sync();
    for (int i = 0; i < 10; i++) sbit(1'(i));
    put(1'b0, 1'b0);
    put(1'b1, 1'b0);
    chk(frame_err && !pkt_valid, "R8", "single SE0", 32'({frame_err, pkt_valid}), 32'h2);
    idle(3);

    // R5 seven ones
    idle(2);
    sync();
    for (int i = 0; i < 6; i++) nrzi(1'b1);
    chk(!stuff_err, "R5", "six ones no error", 32'(stuff_err), 32'h0);
    nrzi(1'b1);
    chk(stuff_err && !pkt_valid, "R5", "seventh one", 32'({stuff_err, pkt_valid}), 32'h2);
    held("R5");
    idle(1);
    chk(!stuff_err, "R12", "stuff_err one cycle", 32'(stuff_err), 32'h0);
    put(1'b0, 1'b0); put(1'b0, 1'b0);
    chk(flags() == 7'b0, "R5", "abandoned packet gives no strobe", 32'(flags()), 32'h0);
    held("R5");
    idle(3);

    // R9 turnaround window
    for (int k = TO - 1; k <= TO + 2; k++) begin
      tx_done = 1'b1;
      put(1'b1, 1'b0);
      tx_done = 1'b0;
      for (int i = 1; i <= TO + 2; i++) begin
        logic exp_to;
        if (i == k) put(1'b0, 1'b1); else put(1'b1, 1'b0);
        exp_to = (i == TO) && (k > TO);
        chk(turn_timeout == exp_to, "R9", $sformatf("timeout k=%0d i=%0d", k, i),
            32'(turn_timeout), 32'(exp_to));
      end
      idle(4);
    end

    // R10 bus reset threshold
    put(1'b0, 1'b0); put(1'b0, 1'b0);
    put(1'b1, 1'b0);
    chk(flags() == 7'b0, "R10", "short SE0 while idle", 32'(flags()), 32'h0);
    for (int i = 1; i < RC; i++) put(1'b0, 1'b0);
    chk(!bus_reset, "R10", "one short of threshold", 32'(bus_reset), 32'h0);
    put(1'b0, 1'b0);
    chk(bus_reset && !frame_err && !pkt_valid, "R10", "reached threshold",
        32'({bus_reset, frame_err, pkt_valid}), 32'h4);
    put(1'b0, 1'b0);
    chk(bus_reset, "R10", "held during SE0", 32'(bus_reset), 32'h1);
    put(1'b1, 1'b0);
    chk(!bus_reset, "R10", "released on J", 32'(bus_reset), 32'h0);
    idle(2);
    good_pkt(3'd6, 4'd1, 16'hBEEF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule